// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Label Filtering

This block takes the two logic-level pulse lines produced by an external comparator stage, one pulsing for each "one" bit and one pulsing for each "zero" bit, and turns the return-to-zero stream into 32-bit words. Both lines are oversampled at ten times the bit rate. A pulse of plausible width becomes a bit. A stretch of at least four bit times with both lines low separates words.

Each complete word can be screened in two ways. The first is an odd-parity check over all 32 bits. The second compares its 8-bit label, the first eight bits on the wire, against a sixteen-entry table that the host programs. Words that pass are stored in a 32-deep queue. An option swaps the label bits into a host-friendly order before the word is stored.

The host takes each stored word as two 16-bit halves through a half-select input. Taking the upper half releases the word from the queue. Three flags report the queue level: at least one word, at least half full, and full. All timing derives from a nominal 1 MHz master clock, with a choice of fast rate (one sample per clock) or slow rate (one sample per eight clocks).

Top module: `a429_rx_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `data_ready`, `half_full` and `full` are 0 and `rd_data` is 0. Reset also invalidates every label table entry, so with `filt_en` = 1 no word is stored until an entry is written.
- R2: Lines are sampled once per clock when `rate_slow` = 0 and once per 8 clocks when `rate_slow` = 1. A pulse on exactly one line lasting 3 to 7 consecutive samples, followed by a low sample, is one bit: `line_one` gives 1 and `line_zero` gives 0.
- R3: At least 40 consecutive samples with both lines low mark a word boundary. Bits are assembled only after such a boundary. A word ending in a boundary with fewer than 32 bits is discarded. Pulses after the 32nd bit are ignored until the next boundary.
- R4: A word is discarded if any sample has both lines high, or if any pulse lasts fewer than 3 or more than 7 samples.
- R5: When `par_chk_en` = 1, a word is stored only if its 32 bits hold an odd number of ones. When it is 0, parity does not affect storage.
- R6: The label is the first 8 received bits, and the first received bit is the label MSB. When `filt_en` = 1, a word is stored only if its label equals a valid table entry. A table entry is written with `lbl_val` at index `lbl_idx` when `lbl_we` = 1. When `filt_en` = 0, every word is stored.
- R7: With `unscramble_en` = 0, bit i of the stored word is the i-th received bit, counting the first as bit 0. With `unscramble_en` = 1, bits [7:0] hold the label value with its MSB at bit 7, and bits [31:8] are unchanged.
- R8: `rd_data` shows bits [15:0] of the oldest word when `half_sel` = 0 and bits [31:16] when `half_sel` = 1. `rd_en` with `half_sel` = 1 removes that word. `rd_en` with `half_sel` = 0 removes nothing.
- R9: `data_ready` = 1 when at least 1 word is held, `half_full` = 1 when at least 16 are held, and `full` = 1 when 32 are held.
- R10: A word that completes while the queue holds 32 words is dropped, and the stored words are unchanged.
- R11: `rd_en` while the queue is empty has no effect, and the next stored word is read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_slow | input | 1 | 0: sample every clock; 1: sample every 8 clocks |
| line_one | input | 1 | Pulse line for one bits |
| line_zero | input | 1 | Pulse line for zero bits |
| filt_en | input | 1 | Enable label filtering |
| par_chk_en | input | 1 | Enable odd-parity screening |
| unscramble_en | input | 1 | Store the label in host bit order |
| lbl_we | input | 1 | Write a label table entry |
| lbl_idx | input | 4 | Table entry index |
| lbl_val | input | 8 | Label value to write |
| rd_en | input | 1 | Read strobe; pops when half_sel is 1 |
| half_sel | input | 1 | 0: lower half, 1: upper half |
| rd_data | output | 16 | Selected half of the oldest word |
| data_ready | output | 1 | Queue holds at least one word |
| half_full | output | 1 | Queue holds at least 16 words |
| full | output | 1 | Queue holds 32 words |

## Verification
A decoder that drifts out of step shows up as a missing or corrupted word at `rd_data`. This is visible within one word time plus the 40-sample boundary after the faulty stimulus. A corrupted queue pointer or count shows in the flags or in the read sequence on the very next pop. That is why the fill-and-drain test compares every word in order and checks the flags at 15, 16, 31 and 32 entries. A label table that is not cleared or is written to the wrong entry shows on the first filtered word, as a `data_ready` level that contradicts the programmed table.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
    localparam int WORD_BITS  = 32;
    localparam int LABEL_BITS = 8;
    localparam int HALF_BITS  = WORD_BITS / 2;

    typedef logic [WORD_BITS-1:0]  word_t;
    typedef logic [LABEL_BITS-1:0] label_t;

    typedef enum logic {PULSE_ZERO = 1'b0, PULSE_ONE = 1'b1} pulse_e;

    typedef struct packed {
        logic filt_en;
        logic par_chk;
        logic unscramble;
    } rx_cfg_t;

    // first received bit is the label MSB
    function automatic label_t label_of(word_t w);
        label_t l;
        for (int i = 0; i < LABEL_BITS; i++) l[LABEL_BITS-1-i] = w[i];
        return l;
    endfunction

    function automatic logic parity_odd(word_t w);
        return ^w;
    endfunction

    function automatic word_t host_order(word_t w, logic unscr);
        word_t r;
        r = w;
        if (unscr) r[LABEL_BITS-1:0] = label_of(w);
        return r;
    endfunction
endpackage

// File: rtl/a429_bit_decoder.sv
module a429_bit_decoder
    import a429_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 10,
    parameter int FAST_DIV   = 1,
    parameter int SLOW_DIV   = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rate_slow,
    input  logic  line_one,
    input  logic  line_zero,
    output logic  word_done,
    output word_t raw_word
);
    localparam int PMIN  = (OVERSAMPLE * 3) / 10;
    localparam int PMAX  = (OVERSAMPLE * 7) / 10;
    localparam int RMAX  = PMAX + 1;
    localparam int GAP   = 4 * OVERSAMPLE;
    localparam int RW    = $clog2(RMAX + 1);
    localparam int GW    = $clog2(GAP + 1);
    localparam int DW    = $clog2(SLOW_DIV + 1);
    localparam int BW    = $clog2(WORD_BITS);

    logic [DW-1:0] div_cnt, div_lim;
    logic          tick;
    logic [RW-1:0] run_len;
    pulse_e        run_line;
    logic [GW-1:0] gap_cnt;
    logic [BW-1:0] bit_cnt;
    logic          armed, bad;

    assign div_lim = rate_slow ? DW'(SLOW_DIV - 1) : DW'(FAST_DIV - 1);
    assign tick    = (div_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else if (div_cnt >= div_lim) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        word_done <= 1'b0;
        if (rst) begin
            run_len  <= '0;
            run_line <= PULSE_ZERO;
            gap_cnt  <= '0;
            bit_cnt  <= '0;
            armed    <= 1'b0;
            bad      <= 1'b0;
            raw_word <= '0;
        end else if (tick) begin
            if (line_one || line_zero) begin
                gap_cnt <= '0;
                if (line_one && line_zero) begin
                    bad     <= 1'b1;
                    run_len <= '0;
                end else if (run_len != '0 && run_line != pulse_e'(line_one)) begin
                    bad      <= 1'b1;
                    run_len  <= RW'(1);
                    run_line <= pulse_e'(line_one);
                end else begin
                    run_line <= pulse_e'(line_one);
                    if (run_len != RW'(RMAX)) run_len <= run_len + 1'b1;
                end
            end else begin
                if (gap_cnt != GW'(GAP)) gap_cnt <= gap_cnt + 1'b1;
                if (gap_cnt == GW'(GAP - 1)) begin
                    armed   <= 1'b1;
                    bit_cnt <= '0;
                    bad     <= 1'b0;
                end
                if (run_len != '0) begin
                    run_len <= '0;
                    if (run_len < RW'(PMIN) || run_len > RW'(PMAX)) begin
                        bad <= 1'b1;
                    end else if (armed && !bad) begin
                        raw_word[bit_cnt] <= (run_line == PULSE_ONE);
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BW'(WORD_BITS - 1)) begin
                            word_done <= 1'b1;
                            armed     <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // R3
    done_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        word_done |-> !armed);

    // R4
    both_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && line_one && line_zero) |=> bad);
endmodule

// File: rtl/a429_label_table.sv
module a429_label_table
    import a429_rx_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] idx,
    input  label_t                     wval,
    input  label_t                     probe,
    output logic                       hit
);
    label_t             lbl [ENTRIES];
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            for (int i = 0; i < ENTRIES; i++) lbl[i] <= '0;
        end else if (we) begin
            valid[idx] <= 1'b1;
            lbl[idx]   <= wval;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (lbl[g] == probe);
    end

    assign hit = |match;

    // R1
    table_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit);
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo
    import a429_rx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  word_t                    wdata,
    input  logic                     pop,
    output word_t                    head,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    word_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count != FULL_CNT);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT && push && !pop) |=> count == FULL_CNT);

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> count == '0);

    // R9
    push_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count != FULL_CNT) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
    import a429_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 10,
    parameter int FAST_DIV   = 1,
    parameter int SLOW_DIV   = 8,
    parameter int LBL_COUNT  = 16,
    parameter int FIFO_DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rate_slow,
    input  logic                         line_one,
    input  logic                         line_zero,
    input  logic                         filt_en,
    input  logic                         par_chk_en,
    input  logic                         unscramble_en,
    input  logic                         lbl_we,
    input  logic [$clog2(LBL_COUNT)-1:0] lbl_idx,
    input  logic [7:0]                   lbl_val,
    input  logic                         rd_en,
    input  logic                         half_sel,
    output logic [15:0]                  rd_data,
    output logic                         data_ready,
    output logic                         half_full,
    output logic                         full
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    rx_cfg_t       cfg;
    logic          word_done, lbl_hit, accept;
    word_t         raw_word, head;
    logic [CW-1:0] count;

    assign cfg = '{filt_en: filt_en, par_chk: par_chk_en, unscramble: unscramble_en};

    a429_bit_decoder #(
        .OVERSAMPLE(OVERSAMPLE), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
    ) u_dec (
        .clk(clk), .rst(rst), .rate_slow(rate_slow),
        .line_one(line_one), .line_zero(line_zero),
        .word_done(word_done), .raw_word(raw_word)
    );

    a429_label_table #(.ENTRIES(LBL_COUNT)) u_tbl (
        .clk(clk), .rst(rst), .we(lbl_we), .idx(lbl_idx), .wval(lbl_val),
        .probe(label_of(raw_word)), .hit(lbl_hit)
    );

    assign accept = (!cfg.par_chk || parity_odd(raw_word)) && (!cfg.filt_en || lbl_hit);

    a429_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(word_done && accept), .wdata(host_order(raw_word, cfg.unscramble)),
        .pop(rd_en && half_sel), .head(head), .count(count)
    );

    assign data_ready = (count != '0);
    assign half_full  = (count >= CW'(FIFO_DEPTH / 2));
    assign full       = (count == CW'(FIFO_DEPTH));
    assign rd_data    = !data_ready ? '0 :
                        half_sel ? head[HALF_BITS +: HALF_BITS] : head[HALF_BITS-1:0];

    // R9
    flag_nesting_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (half_full && data_ready));

    // R8
    lower_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !half_sel && !word_done) |=> $stable(count));
endmodule

// File: tb/a429_rx_filter_test.sv
module a429_rx_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_slow = 1'b0, line_one = 1'b0, line_zero = 1'b0;
    logic        filt_en = 1'b0, par_chk_en = 1'b0, unscramble_en = 1'b0;
    logic        lbl_we = 1'b0;
    logic [3:0]  lbl_idx = '0;
    logic [7:0]  lbl_val = '0;
    logic        rd_en = 1'b0, half_sel = 1'b0;
    logic [15:0] rd_data;
    logic        data_ready, half_full, full;

    int n_chk = 0, n_fail = 0, sdiv = 1;
    bit done = 0;
    logic [7:0] m_lbl [16];
    bit         m_ok  [16];

    // {raw word, filt, par, unscr}
    localparam logic [34:0] VECS [9] = '{
        {32'h1234_56A1, 3'b000}, {32'h1234_56A1, 3'b101}, {32'hABCD_EF8C, 3'b100},
        {32'h0000_0F03, 3'b100}, {32'h8000_0001, 3'b010}, {32'h8000_0000, 3'b010},
        {32'h0000_0001, 3'b001}, {32'hFFFF_FFFF, 3'b110}, {32'h7FFF_FFFF, 3'b111}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_rx_filter uut (
        .clk(clk), .rst(rst), .rate_slow(rate_slow), .line_one(line_one),
        .line_zero(line_zero), .filt_en(filt_en), .par_chk_en(par_chk_en),
        .unscramble_en(unscramble_en), .lbl_we(lbl_we), .lbl_idx(lbl_idx),
        .lbl_val(lbl_val), .rd_en(rd_en), .half_sel(half_sel), .rd_data(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full)
    );

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    function automatic bit exp_keep(logic [31:0] w, bit f, bit p);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (m_ok[i] && m_lbl[i] == rev8(w[7:0])) hit = 1;
        return (!p || ($countones(w) % 2 == 1)) && (!f || hit);
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] w, bit u);
        return u ? {w[31:8], rev8(w[7:0])} : w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic o, input logic z, input int n);
        line_one = o; line_zero = z;
        repeat (n * sdiv) @(negedge clk);
    endtask

    // mode: 0 clean, 1 both high, 2 long pulse, 3 short pulse (at bit 'at')
    task automatic send(input logic [31:0] w, input int nbits, input int mode, input int at);
        for (int b = 0; b < nbits; b++) begin
            if (mode == 1 && b == at) put(1'b1, 1'b1, 5);
            else put(w[b % 32], !w[b % 32], (b == at && mode == 2) ? 9 : (b == at && mode == 3) ? 2 : 5);
            put(1'b0, 1'b0, 5);
        end
        put(1'b0, 1'b0, 45);
    endtask

    task automatic prog(input int i, input logic [7:0] v);
        lbl_we = 1'b1; lbl_idx = 4'(i); lbl_val = v;
        @(negedge clk);
        lbl_we = 1'b0;
        m_lbl[i] = v; m_ok[i] = 1;
    endtask

    task automatic read_word(output logic [31:0] w, input bit pop);
        half_sel = 1'b0; #1 w[15:0] = rd_data;
        half_sel = 1'b1; #1 w[31:16] = rd_data;
        if (pop) begin
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        end else @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) m_ok[i] = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 16; i++) begin m_ok[i] = 0; m_lbl[i] = '0; end
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk({data_ready, half_full, full} == 3'b000, "R1 flags", {29'd0, data_ready, half_full, full}, 0);
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        put(1'b0, 1'b0, 45);

        prog(0, 8'h85); prog(5, 8'h31); prog(15, 8'hFF);

        // R5 R6 R7 vector table
        for (int v = 0; v < 9; v++) begin
            logic [31:0] w;
            bit keep;
            w = VECS[v][34:3];
            filt_en = VECS[v][2]; par_chk_en = VECS[v][1]; unscramble_en = VECS[v][0];
            keep = exp_keep(w, filt_en, par_chk_en);
            send(w, 32, 0, -1);
            chk(data_ready == keep, "R5/R6 store decision", {31'd0, data_ready}, {31'd0, keep});
            if (keep) begin
                read_word(got, 1);
                chk(got == exp_word(w, unscramble_en), "R7/R8 word content", got, exp_word(w, unscramble_en));
                chk(!data_ready, "R8 upper read pops", {31'd0, data_ready}, 0);
            end
        end
        filt_en = 0; par_chk_en = 0; unscramble_en = 0;

        // R3 short word discarded
        send(32'hFFFF_0000, 20, 0, -1);
        chk(!data_ready, "R3 short word", {31'd0, data_ready}, 0);
        // R3 extra pulses after 32 bits ignored
        send(32'h5A5A_3C3C, 35, 0, -1);
        chk(data_ready, "R3 overlong stored", {31'd0, data_ready}, 1);
        read_word(got, 1);
        chk(got == 32'h5A5A_3C3C, "R3 first 32 bits", got, 32'h5A5A_3C3C);
        // R4 malformed
        send(32'h1111_2222, 32, 1, 10);
        chk(!data_ready, "R4 both high", {31'd0, data_ready}, 0);
        send(32'h1111_2222, 32, 2, 4);
        chk(!data_ready, "R4 long pulse", {31'd0, data_ready}, 0);
        send(32'h1111_2222, 32, 3, 20);
        chk(!data_ready, "R4 short pulse", {31'd0, data_ready}, 0);

        // R2 slow rate
        rate_slow = 1; sdiv = 8;
        put(1'b0, 1'b0, 45);
        send(32'hC0FF_EE11, 32, 0, -1);
        read_word(got, 1);
        chk(got == 32'hC0FF_EE11, "R2 slow rate word", got, 32'hC0FF_EE11);
        rate_slow = 0; sdiv = 1;
        put(1'b0, 1'b0, 45);

        // R9 R10 fill
        for (int i = 0; i < 33; i++) begin
            send(32'h0100_0000 + 32'(i), 32, 0, -1);
            if (i == 14) chk(!half_full, "R9 half_full at 15", {31'd0, half_full}, 0);
            if (i == 15) chk(half_full, "R9 half_full at 16", {31'd0, half_full}, 1);
            if (i == 30) chk(!full, "R9 full at 31", {31'd0, full}, 0);
            if (i == 31) chk(full, "R9 full at 32", {31'd0, full}, 1);
        end
        chk(full, "R10 still full", {31'd0, full}, 1);
        read_word(got, 0);
        read_word(got, 0);
        chk(got == 32'h0100_0000, "R8 lower read keeps head", got, 32'h0100_0000);
        for (int i = 0; i < 32; i++) begin
            read_word(got, 1);
            chk(got == 32'h0100_0000 + 32'(i), "R10 drain order", got, 32'h0100_0000 + 32'(i));
        end
        chk(!data_ready, "R10 dropped word absent", {31'd0, data_ready}, 0);

        // R11 pop on empty
        read_word(got, 1);
        chk(rd_data == 0 && !data_ready, "R11 empty pop", {15'd0, data_ready, rd_data}, 0);
        send(32'h0BAD_F00D, 32, 0, -1);
        read_word(got, 1);
        chk(got == 32'h0BAD_F00D, "R11 next word", got, 32'h0BAD_F00D);

        // R1 table cleared by reset
        do_reset();
        filt_en = 1;
        put(1'b0, 1'b0, 45);
        send(32'h0000_0000, 32, 0, -1);
        chk(!data_ready, "R1 label 00 not matched", {31'd0, data_ready}, 0);
        send(32'h1234_56A1, 32, 0, -1);
        chk(!data_ready, "R1 old label cleared", {31'd0, data_ready}, 0);

        done = 1;
        summary();
    end
endmodule